// File: doc/BRIEF.md
# Warp memory access coalescer

This block takes one load request from a 32-lane warp. Each lane has an active flag and a 32-bit byte address. The block merges the active lanes into the fewest aligned 128-byte segment transactions. It then issues those transactions one at a time toward memory over a valid/ready handshake.

Each transaction carries the base address of its segment and a 32-bit mask of the lanes it serves. A segment is always fetched whole, even when only one word of it was asked for. Every lane reads a naturally aligned 4-byte word, so a lane never touches two segments.

The next pending segment is found in two steps. A priority pick selects the lowest-numbered pending lane. A parallel compare then marks every pending lane that shares that lane's segment. As a result, one transaction can leave per cycle while memory keeps its ready high. The warp side accepts a new request only after every transaction of the current one has been accepted downstream.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `txn_valid` and `done` are low and `req_ready` is high.
- R2: Every issued `txn_base` equals a served lane's address with bits 6:0 cleared, so it is always a multiple of 128.
- R3: Each transaction's mask sets bit i exactly for the pending active lanes i whose address has the same bits 31:7 as the transaction's lead lane.
- R4: A request issues exactly one transaction per distinct 128-byte segment among its active lanes, and no segment appears twice.
- R5: Transactions leave in increasing order of their lowest-numbered still-pending active lane.
- R6: Lanes with a low active flag are ignored. A request with no active lanes issues no transaction, and `done` is high in the same cycle it is accepted.
- R7: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_base` and `txn_mask` keep their values in the next cycle.
- R8: `done` is high exactly in the cycle the last transaction of a request is accepted. `req_ready` is high in the cycle after that.
- R9: When the 32 lanes access consecutive 4-byte words starting on a 128-byte boundary, exactly one transaction is issued, with mask 0xFFFFFFFF.
- R10: With `txn_ready` held high, a new transaction is offered in every cycle until the request is complete.
- R11: While a request is being issued, `req_ready` is low, and a `req_valid` offered then has no effect on the transactions issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A warp load request is offered |
| req_ready | output | 1 | Block is idle and can take a request |
| req_active | input | 32 | Active flag per lane, bit i for lane i |
| req_addr | input | 1024 | Lane byte addresses; lane i at bits 32*i+31 : 32*i |
| txn_valid | output | 1 | A segment transaction is offered |
| txn_ready | input | 1 | Memory accepts the offered transaction |
| txn_base | output | 32 | 128-byte aligned base of the segment |
| txn_mask | output | 32 | Lanes served by this transaction |
| done | output | 1 | Final transaction of the request accepted this cycle, or an empty request accepted |

## Verification
A wrong pending mask appears at the ports in the cycle after the handshake that caused it. It shows as a repeated segment, a skipped segment, or a `done` that comes early or never comes. A stale stored segment shows as a wrong `txn_base` on the first transaction whose lead lane reads it. The bench sweeps the alignment offset of a contiguous warp word by word. It also runs many random warps drawn from a small pool of segments, under random backpressure, with random active masks. Each offered transaction is compared in the same cycle against a sequence computed arithmetically from the lane addresses.

// File: rtl/coal_pkg.sv
package coal_pkg;

    localparam int LANES     = 32;
    localparam int AW        = 32;
    localparam int SEG_SHIFT = 7;
    localparam int SEG_W     = AW - SEG_SHIFT;
    localparam int LIDX_W    = $clog2(LANES);

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [LANES-1:0]  lmask_t;
    typedef logic [LIDX_W-1:0] lidx_t;
    typedef logic [AW-1:0]     addr_t;

    typedef struct packed {
        addr_t  base;
        lmask_t lanes;
    } txn_t;

    function automatic seg_t seg_of(input addr_t a);
        return a[AW-1:SEG_SHIFT];
    endfunction

    function automatic addr_t seg_base(input seg_t s);
        return {s, {SEG_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/coal_seg_store.sv
module coal_seg_store
    import coal_pkg::*;
(
    input  logic                clk,
    input  logic                load,
    input  logic [LANES*AW-1:0] addr_flat,
    output seg_t                segs [LANES]
);
    logic [LANES*SEG_SHIFT-1:0] unused_low;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign unused_low[g*SEG_SHIFT +: SEG_SHIFT] = addr_flat[g*AW +: SEG_SHIFT];
        always_ff @(posedge clk) begin
            if (load) begin
                segs[g] <= seg_of(addr_flat[g*AW +: AW]);
            end
        end
    end
endmodule

// File: rtl/coal_lane_pick.sv
module coal_lane_pick
    import coal_pkg::*;
(
    input  lmask_t pending,
    output lidx_t  lead,
    output logic   any
);
    always_comb begin
        lead = '0;
        any  = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                lead = LIDX_W'(i);
                any  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coal_seg_match.sv
module coal_seg_match
    import coal_pkg::*;
(
    input  seg_t   segs [LANES],
    input  seg_t   lead_seg,
    input  lmask_t pending,
    output lmask_t hit
);
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign hit[g] = pending[g] && (segs[g] == lead_seg);
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LANES-1:0]    req_active,
    input  logic [LANES*AW-1:0] req_addr,
    output logic                txn_valid,
    input  logic                txn_ready,
    output logic [AW-1:0]       txn_base,
    output logic [LANES-1:0]    txn_mask,
    output logic                done
);
    lmask_t pending_q;
    seg_t   segs [LANES];
    lidx_t  lead;
    logic   any;
    seg_t   lead_seg;
    lmask_t hit;
    lmask_t remain;
    txn_t   cur;
    logic   accept;
    logic   fire;

    assign req_ready = (pending_q == '0);
    assign accept    = req_valid && req_ready;

    coal_seg_store u_store (
        .clk       (clk),
        .load      (accept),
        .addr_flat (req_addr),
        .segs      (segs)
    );

    coal_lane_pick u_pick (
        .pending (pending_q),
        .lead    (lead),
        .any     (any)
    );

    assign lead_seg = segs[lead];

    coal_seg_match u_match (
        .segs     (segs),
        .lead_seg (lead_seg),
        .pending  (pending_q),
        .hit      (hit)
    );

    assign cur.base  = seg_base(lead_seg);
    assign cur.lanes = hit;

    assign txn_valid = any;
    assign txn_base  = cur.base;
    assign txn_mask  = cur.lanes;

    assign fire   = txn_valid && txn_ready;
    assign remain = pending_q & ~hit;
    assign done   = (fire && (remain == '0)) || (accept && (req_active == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= '0;
        end else if (accept) begin
            pending_q <= req_active;
        end else if (fire) begin
            pending_q <= remain;
        end
    end

    // R7: an offered transaction holds while stalled
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_mask)));

    // R8: the request side reopens after the final handshake
    a_r8_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        (done && txn_valid) |=> req_ready);

    // R3: an offered transaction always serves at least its lead lane
    a_r3_mask_nonempty: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_mask != '0));

    // R4: successive transactions of one request serve disjoint lanes
    a_r4_disjoint: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_ready && !done) |=> (txn_valid && ((txn_mask & $past(txn_mask)) == '0)));

    // R11: no request is taken while transactions are pending
    a_r11_busy_closed: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> !req_ready);
endmodule

// File: tb/sim_warp_coalescer.sv
module sim_warp_coalescer;
    localparam int NL = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [NL-1:0]   req_active = '0;
    logic [NL*32-1:0] req_addr = '0;
    logic            txn_valid;
    logic            txn_ready = 1'b0;
    logic [31:0]     txn_base;
    logic [NL-1:0]   txn_mask;
    logic            done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [31:0]   lane_a [NL];
    logic [NL-1:0] act;
    logic [31:0]   exp_base [NL];
    logic [NL-1:0] exp_mask [NL];
    int            exp_n;

    always #10 clk = ~clk;

    warp_coalescer u0 (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_active (req_active),
        .req_addr   (req_addr),
        .txn_valid  (txn_valid),
        .txn_ready  (txn_ready),
        .txn_base   (txn_base),
        .txn_mask   (txn_mask),
        .done       (done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks = checks + 1;
        if (act_v !== exp_v) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act_v, exp_v);
        end
    endtask

    task automatic build_expect();
        logic [NL-1:0] pend;
        pend  = act;
        exp_n = 0;
        while (pend != '0) begin
            int ld;
            logic [NL-1:0] m;
            ld = 0;
            for (int i = NL - 1; i >= 0; i--) if (pend[i]) ld = i;
            m = '0;
            for (int i = 0; i < NL; i++)
                if (pend[i] && ((lane_a[i] >> 7) == (lane_a[ld] >> 7))) m[i] = 1'b1;
            exp_base[exp_n] = (lane_a[ld] >> 7) << 7;
            exp_mask[exp_n] = m;
            exp_n = exp_n + 1;
            pend = pend & ~m;
        end
    endtask

    task automatic run_warp(input string tag, input bit stall);
        int k;
        int guard;
        bit held;
        logic [31:0]   hb;
        logic [NL-1:0] hm;
        build_expect();
        @(negedge clk);
        req_valid  = 1'b1;
        req_active = act;
        for (int i = 0; i < NL; i++) req_addr[i*32 +: 32] = lane_a[i];
        txn_ready = 1'b0;
        #1;
        chk("R8 ready before request", 32'(req_ready), 32'd1);
        if (exp_n == 0) chk("R6 empty request done", 32'(done), 32'd1);
        k = 0;
        held = 1'b0;
        guard = 0;
        while (k < exp_n && guard < 400) begin
            bit rdy;
            guard++;
            @(negedge clk);
            req_valid  = 1'b1;
            req_active = '1;
            for (int i = 0; i < NL; i++) req_addr[i*32 +: 32] = 32'h7700_0000 + 32'(i * 256);
            rdy = stall ? (($urandom % 3) != 0) : 1'b1;
            txn_ready = rdy;
            #1;
            chk("R10 transaction offered", 32'(txn_valid), 32'd1);
            chk("R11 request side closed", 32'(req_ready), 32'd0);
            chk({"R2/R5 base ", tag}, txn_base, exp_base[k]);
            chk({"R3/R4 mask ", tag}, txn_mask, exp_mask[k]);
            if (held) begin
                chk("R7 base held", txn_base, hb);
                chk("R7 mask held", txn_mask, hm);
            end
            chk("R8 done pulse", 32'(done), 32'(rdy && (k == exp_n - 1)));
            if (rdy) begin
                k++;
                held = 1'b0;
            end else begin
                held = 1'b1;
                hb = txn_base;
                hm = txn_mask;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        txn_ready = 1'b1;
        #1;
        chk({"R4 count/idle ", tag}, 32'(txn_valid), 32'd0);
        chk("R8 ready after done", 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset valid", 32'(txn_valid), 32'd0);
        chk("R1 reset ready", 32'(req_ready), 32'd1);
        chk("R1 reset done", 32'(done), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R9: aligned contiguous warp, one full transaction
        act = '1;
        for (int i = 0; i < NL; i++) lane_a[i] = 32'h0000_1000 + 32'(4 * i);
        build_expect();
        chk("R9 single transaction", 32'(exp_n), 32'd1);
        run_warp("R9", 1'b0);

        // R4: sweep of word offsets for a contiguous warp
        for (int o = 0; o < 32; o++) begin
            for (int i = 0; i < NL; i++) lane_a[i] = 32'h0004_0000 + 32'(4 * (o + i));
            run_warp("R4 offset sweep", o[0]);
        end

        // R4: every lane in its own segment
        for (int i = 0; i < NL; i++) lane_a[i] = 32'h0010_0000 + 32'(128 * i) + 32'(4 * (i % 32));
        run_warp("R4 scattered", 1'b0);
        run_warp("R4 scattered stall", 1'b1);

        // R6: no active lanes
        act = '0;
        run_warp("R6 empty", 1'b0);
        act = '0;
        act[17] = 1'b1;
        for (int i = 0; i < NL; i++) lane_a[i] = 32'hDEAD_BEEC ^ 32'(i * 128);
        run_warp("R6 single lane", 1'b1);

        // R5: lane 0 sits in the higher segment, so it leads
        act = '1;
        for (int i = 0; i < NL; i++)
            lane_a[i] = (i % 2 == 0) ? 32'h0000_5000 + 32'(4 * i) : 32'h0000_3000 + 32'(4 * i);
        run_warp("R5 order", 1'b1);

        // R9: reversed lane order inside one segment
        for (int i = 0; i < NL; i++) lane_a[i] = 32'h0000_2000 + 32'(4 * (31 - i));
        run_warp("R9 reversed", 1'b0);

        // random warps from a small segment pool
        for (int w = 0; w < 300; w++) begin
            logic [31:0] pool [4];
            for (int p = 0; p < 4; p++) pool[p] = ($urandom & 32'hFFFF_FF80) | 32'(p * 128);
            act = (w % 7 == 0) ? '1 : $urandom;
            for (int i = 0; i < NL; i++)
                lane_a[i] = pool[$urandom % 4] + (($urandom % 32) * 4);
            run_warp("R3 random", w[0]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule